// File: doc/BRIEF.md
# Single-Level Page Table Walker

This unit turns a 32-bit virtual address into a physical address by fetching one page table entry from memory. The virtual address splits into a 20-bit page number and a 12-bit in-page offset (4 KB pages). The page number indexes a table of 4-byte entries whose start is given by a table base input. The unit checks the entry's valid bit and its rights against the kind of access requested. It then returns either a physical address or a fault code. Loading a different table base points the unit at another process's table.

A request enters over a valid/ready channel. The table entry is read through a request channel (valid/ready) and a response channel (valid/ready). The outcome leaves over a third valid/ready channel. On every channel, a sender that has raised valid keeps valid high and its payload stable until the cycle in which ready is also high. The unit handles one walk at a time. It takes no new request until its result has been accepted.

Top module: `ptw_unit`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0.
- R2: The entry read address is `table_base + (vaddr[31:12] << 2)` modulo 2^32. `table_base` is sampled in the cycle the request is accepted, so a change to `table_base` during a walk does not affect that walk.
- R3: An entry has the valid flag in bit 31, the rights in bits 30:29 and the physical page number in bits 19:0. A walk with no fault returns `res_paddr = {entry[19:0], vaddr[11:0]}`, so the offset passes through unchanged.
- R4: An entry with bit 31 equal to 0 gives `res_fault` = 01 (page fault) and `res_paddr` = 0, whatever its rights and the access kind.
- R5: Access kinds on `req_kind` are 00 read, 01 write, 10 instruction fetch, and 11 is treated as read. Rights codes are 00 none, 01 read-only, 10 read/write, 11 executable. Read is allowed on rights 01, 10 and 11. Write is allowed only on 10. Fetch is allowed only on 11. Rights 00 allow nothing. A valid entry that does not allow the access gives `res_fault` = 10 (protection fault) and `res_paddr` = 0.
- R6: A valid entry that allows the access gives `res_fault` = 00.
- R7: `req_ready` falls in the cycle after a request is accepted. It stays low until the result handshake completes, and is high again in the following cycle.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request and `mem_req_addr` are held. While `res_valid` is high and `res_ready` is low, `res_valid`, `res_paddr` and `res_fault` are held.
- R9: `mem_rsp_ready` is high only while a read request has been issued and no response has been taken. `res_valid` rises in the cycle after the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_base | input | 32 | Byte address of the current process's page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| mem_req_valid | output | 1 | Entry read request present |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_ready | output | 1 | Unit waiting for entry data |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
Every pairing of the four rights codes with the three access kinds is driven against a valid entry. This separates the allow and deny cases of the rights decision. Invalid entries that carry executable rights show whether the page fault wins over the rights check. A walk whose table base is replaced right after acceptance, and a base near the top of the address space, test index formation and base sampling. Random addresses, kinds, bases, memory stalls and result stalls exercise the handshakes on all three channels against entries computed by a bench function.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    RIGHTS_NONE = 2'b00,
    RIGHTS_RO   = 2'b01,
    RIGHTS_RW   = 2'b10,
    RIGHTS_EX   = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESULT
  } walk_st_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W     = 32,
  parameter int VPN_W    = 20,
  parameter int ESZ_LOG2 = 2
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  entry_addr
);
  logic [PA_W-1:0] index_bytes;

  assign index_bytes = PA_W'(vpn) << ESZ_LOG2;
  assign entry_addr  = base + index_bytes;
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [OFF_W-1:0] offset,
  input  acc_e             kind,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);
  localparam int PPN_W = PA_W - OFF_W;

  logic             ent_valid;
  rights_e          rights;
  logic [PPN_W-1:0] ppn;
  logic             allowed;
  logic             unused_pte_bits;

  assign ent_valid       = pte[PTE_W-1];
  assign rights          = rights_e'(pte[PTE_W-2 -: 2]);
  assign ppn             = pte[PPN_W-1:0];
  assign unused_pte_bits = ^pte[PTE_W-4:PPN_W];

  always_comb begin
    unique case (kind)
      ACC_WRITE: allowed = (rights == RIGHTS_RW);
      ACC_FETCH: allowed = (rights == RIGHTS_EX);
      default:   allowed = (rights != RIGHTS_NONE);
    endcase
  end

  always_comb begin
    if (!ent_valid) begin
      fault = FLT_PAGE;
      paddr = '0;
    end else if (!allowed) begin
      fault = FLT_PROT;
      paddr = '0;
    end else begin
      fault = FLT_NONE;
      paddr = {ppn, offset};
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  input  acc_e             req_kind,
  input  logic [PA_W-1:0]  entry_addr_in,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  fault_e           chk_fault,
  input  logic [PA_W-1:0]  chk_paddr,
  output logic [OFF_W-1:0] off_q,
  output acc_e             kind_q,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [PA_W-1:0]  res_paddr,
  output fault_e           res_fault
);
  walk_st_e        state;
  logic [PA_W-1:0] addr_q;
  logic [PA_W-1:0] paddr_q;
  fault_e          fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      kind_q  <= ACC_READ;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          off_q  <= req_off;
          kind_q <= req_kind;
          addr_q <= entry_addr_in;
          state  <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          paddr_q <= chk_paddr;
          fault_q <= chk_fault;
          state   <= ST_RESULT;
        end
        ST_RESULT: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (state == ST_WAIT);
  assign res_valid     = (state == ST_RESULT);
  assign res_paddr     = paddr_q;
  assign res_fault     = fault_q;

  // R8
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_fault)));

  // R9
  res_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(mem_rsp_valid && mem_rsp_ready));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/ptw_unit.sv
module ptw_unit
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int OFF_W    = 12,
  parameter int PTE_W    = 32,
  parameter int ESZ_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] table_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [PA_W-1:0] res_paddr,
  output logic [1:0]      res_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [PA_W-1:0]  entry_addr;
  logic [OFF_W-1:0] off_q;
  acc_e             kind_q;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_paddr;
  fault_e           fault_out;

  ptw_entry_addr #(.PA_W(PA_W), .VPN_W(VPN_W), .ESZ_LOG2(ESZ_LOG2)) u_addr (
    .base       (table_base),
    .vpn        (req_vaddr[VA_W-1:OFF_W]),
    .entry_addr (entry_addr)
  );

  ptw_perm_check #(.PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .pte    (mem_rsp_data),
    .offset (off_q),
    .kind   (kind_q),
    .fault  (chk_fault),
    .paddr  (chk_paddr)
  );

  ptw_ctrl #(.PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .req_kind      (acc_e'(req_kind)),
    .entry_addr_in (entry_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .chk_fault     (chk_fault),
    .chk_paddr     (chk_paddr),
    .off_q         (off_q),
    .kind_q        (kind_q),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_paddr     (res_paddr),
    .res_fault     (fault_out)
  );

  assign res_fault = fault_out;

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fault_out == FLT_NONE) |-> (res_paddr[OFF_W-1:0] == off_q));

  // R4
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fault_out != FLT_NONE) |-> (res_paddr == '0));
endmodule

// File: tb/ptw_unit_bench.sv
module ptw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] table_base;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        res_valid, res_ready;
  logic [31:0] res_paddr;
  logic [1:0]  res_fault;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;

  int errors = 0;
  int checks = 0;
  bit force_en = 1'b0;
  logic [31:0] force_pte = '0;
  logic [31:0] seen_addr = '0;

  always #4 clk = ~clk;

  ptw_unit u_ptw_unit (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr), .res_fault(res_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_for(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    return h;
  endfunction

  function automatic logic [31:0] model_pte(input logic [31:0] a);
    return force_en ? force_pte : pte_for(a);
  endfunction

  function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic [1:0] kind);
    logic ok;
    if (!pte[31]) return 2'b01;
    case (kind)
      2'b01:   ok = (pte[30:29] == 2'b10);
      2'b10:   ok = (pte[30:29] == 2'b11);
      default: ok = (pte[30:29] != 2'b00);
    endcase
    return ok ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [31:0] exp_paddr(input logic [31:0] pte, input logic [31:0] va, input logic [1:0] kind);
    return (exp_fault(pte, kind) == 2'b00) ? {pte[19:0], va[11:0]} : 32'h0;
  endfunction

  // memory model, all decisions at the falling edge
  bit          req_fire_prev = 0, rsp_fire_prev = 0, pend = 0;
  logic [31:0] pend_addr = '0;
  int          delay = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      req_fire_prev = 0; rsp_fire_prev = 0; pend = 0;
    end else begin
      if (rsp_fire_prev) begin
        mem_rsp_valid = 1'b0;
        // R9: result appears the cycle after the response handshake
        check(res_valid === 1'b1, "R9 res_valid after response", {31'b0, res_valid}, 32'h1);
      end
      if (req_fire_prev) begin
        pend = 1; pend_addr = seen_addr; delay = int'($urandom % 4);
      end
      if (pend && !mem_rsp_valid) begin
        if (delay == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = model_pte(pend_addr); pend = 0;
        end else delay--;
      end
      mem_req_ready = ($urandom % 3) != 0;
      req_fire_prev = mem_req_valid && mem_req_ready;
      if (req_fire_prev) seen_addr = mem_req_addr;
      rsp_fire_prev = mem_rsp_valid && mem_rsp_ready;
    end
  end

  task automatic run(input logic [31:0] va, input logic [1:0] kind, input bit chg_base,
                     input logic [31:0] new_base, input int stall, input string tag);
    logic [31:0] eaddr, pte;
    logic [1:0]  f;
    logic [31:0] p;
    int          t;
    eaddr = table_base + ({12'b0, va[31:12]} << 2);
    req_vaddr = va; req_kind = kind; req_valid = 1'b1;
    t = 0;
    while (!req_ready && t < 50) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    if (chg_base) table_base = new_base;
    // R7: busy right after acceptance
    check(req_ready === 1'b0, {tag, " R7 busy after accept"}, {31'b0, req_ready}, 32'h0);
    t = 0;
    while (!res_valid && t < 60) begin
      @(negedge clk); t++;
      if (!res_valid) check(req_ready === 1'b0, {tag, " R7 busy during walk"}, {31'b0, req_ready}, 32'h0);
    end
    if (!res_valid) begin
      checks++; errors++;
      $display("FAIL %s R9 watchdog: no result actual=0 expected=1", tag);
      return;
    end
    pte = model_pte(eaddr);
    // R2: entry address from sampled base and page number
    check(seen_addr === eaddr, {tag, " R2 entry address"}, seen_addr, eaddr);
    // R4 R5 R6: fault code
    check(res_fault === exp_fault(pte, kind), {tag, " R4/R5/R6 fault code"}, {30'b0, res_fault}, {30'b0, exp_fault(pte, kind)});
    // R3: physical address
    check(res_paddr === exp_paddr(pte, va, kind), {tag, " R3 physical address"}, res_paddr, exp_paddr(pte, va, kind));
    f = res_fault; p = res_paddr;
    repeat (stall) @(negedge clk);
    if (stall > 0)
      check(res_valid === 1'b1 && res_fault === f && res_paddr === p, {tag, " R8 result held"}, res_paddr, p);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(req_ready === 1'b1, {tag, " R7 idle after result"}, {31'b0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; table_base = 32'h0010_0000; req_valid = 0; req_vaddr = '0; req_kind = '0; res_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready === 1'b1, "R1 req_ready after reset", {31'b0, req_ready}, 32'h1);
    check(res_valid === 1'b0, "R1 res_valid after reset", {31'b0, res_valid}, 32'h0);
    check(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);

    // R5 R6: every rights code against every access kind
    force_en = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) begin
        force_pte = {1'b1, 2'(r), 9'h0, 20'hABCDE};
        run(32'h1234_5678 + 32'(k), 2'(k), 1'b0, '0, 1, "sweep");
      end
    end
    // R4: invalid entry with executable rights stays a page fault
    for (int k = 0; k < 3; k++) begin
      force_pte = {1'b0, 2'b11, 9'h1FF, 20'hFFFFF};
      run(32'hFFFF_FFFF, 2'(k), 1'b0, '0, 0, "R4 invalid");
    end
    force_en = 1'b0;

    // R2: base replaced right after acceptance does not affect this walk
    table_base = 32'h0040_0000;
    run(32'h0000_3ABC, 2'b00, 1'b1, 32'h0080_0000, 2, "R2 base switch");
    run(32'h0000_3ABC, 2'b00, 1'b0, '0, 0, "R2 new process");
    // R2: wraparound of base + index, page number zero
    table_base = 32'hFFFF_FFF0;
    run(32'h0000_0FFF, 2'b00, 1'b0, '0, 0, "R2 vpn zero");
    run(32'h0001_0123, 2'b01, 1'b0, '0, 0, "R2 wrap");

    // random traffic
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 8 == 0) table_base = $urandom & 32'hFFFF_FFFC;
      run($urandom, 2'($urandom % 3), ($urandom % 10) == 0, $urandom, int'($urandom % 4), "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule